// File: doc/BRIEF.md
# Two-Wire Bus Unstick Engine

This block frees a two-wire serial bus (I2C style) after an error has left the data line held low by some device, or has left the controller's bus-busy flag set with no transfer under way. When asked to recover, it first puts the attached controller back into the not-addressed slave state and arms a Start. It then samples the lines. While SDA reads low, it clocks out one SCL pulse at a time and samples again, so that a slave stuck mid-byte can shift out its remaining bits. Once SDA reads high, it clears the busy flag and sends the armed Start, followed at once by a Stop. This hands a free bus back to the normal transfer engine.

A separate monitor watches both lines while the busy flag is set. It reports the bus as idle once neither line has changed for a programmable number of clock cycles. The busy flag can only be cleared, by software request or by the recovery sequence, when the bus is idle or the flag is already clear. This prevents a forced Start or Stop from cutting into another master's transfer. A clock line held low from outside cannot be freed by this block. It only reports that case. Both lines are driven open-drain: an output high means "pull the line low". The sense inputs carry the wired line levels.

Top module: `twb_unstick`

## Requirements
- R1: A recovery request while the engine is idle gives a one-cycle `slaveReinit` pulse on the next cycle. `startArmed` then goes high in the following cycle and stays high until the done pulse.
- R2: If SCL is sensed low at a sample point, recovery ends with status 2 (SCL stuck). No SCL pulse and no SDA drive are produced.
- R3: If SDA is sensed low while SCL is high at a sample point, the engine drives exactly one SCL low pulse and then samples again.
- R4: If SDA is sensed high at the first sample point, no SCL pulse is produced and the engine goes straight to the busy-clear step.
- R5: Every generated SCL low phase, and every high phase between two generated pulses, lasts at least `halfPeriod` clock cycles (`halfPeriod` must be at least 4).
- R6: If SDA is still low after `MAX_PULSES` generated pulses (default 9), recovery ends with status 3 (SDA stuck) and no Start is sent.
- R7: After SDA reads high, the busy flag is cleared once the bus is idle or not busy. Then SDA is driven low while SCL is released (a Start), `masterSent` goes high, and SDA is released (a Stop). Recovery ends with status 1 (success).
- R8: `busBusy` is set when SDA falls while SCL is high, and cleared when SDA rises while SCL is high.
- R9: `busIdle` is high only while `busBusy` is high and no edge has been seen on either line for `idleThresh` cycles. Any SCL or SDA edge restarts the count.
- R10: `busyClearReq` clears `busBusy` only when `busIdle` is high. At any other time it has no effect.
- R11: `recoveryDone` is a one-cycle pulse. `recoveryStatus` reads 0 from the start of a recovery until its end, and then holds the result code (1 success, 2 SCL stuck, 3 SDA stuck) until the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| recoverReq | input | 1 | Start a recovery sequence (taken only when the engine is idle) |
| busyClearReq | input | 1 | Request to clear the busy flag; acted on only when the bus is idle |
| halfPeriod | input | TW (16) | Minimum SCL phase length in clock cycles |
| idleThresh | input | IW (16) | Cycles without a line edge before the bus counts as idle |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclDriveLow | output | 1 | Pull SCL low (open-drain enable) |
| sdaDriveLow | output | 1 | Pull SDA low (open-drain enable) |
| slaveReinit | output | 1 | One-cycle pulse returning the controller to not-addressed slave |
| startArmed | output | 1 | A Start attempt is pending during recovery |
| masterSent | output | 1 | The recovery Start was put on the bus |
| busBusy | output | 1 | Bus-busy flag |
| busIdle | output | 1 | Bus idle for the programmed period while busy |
| recoveryDone | output | 1 | One-cycle end-of-recovery pulse |
| recoveryStatus | output | 2 | Result code: 0 none, 1 success, 2 SCL stuck, 3 SDA stuck |

## Verification
The hardest case is a slave that lets go of SDA partway through the pulse train. The release has to happen while SCL is low, so that it is not seen as a Stop and the busy flag stays set. The engine must then stop pulsing after exactly the right count and wait out the idle period before its Start. The bench models the wired-AND bus itself. Its line monitor releases SDA at the SCL low phase that follows a chosen number of falling edges. From that it checks the pulse count, the phase widths, and the Start and Stop it sees on the lines.

// File: rtl/unstickPkg.sv
package unstickPkg;

  typedef enum logic [1:0] {
    RES_NONE      = 2'd0,
    RES_OK        = 2'd1,
    RES_SCL_STUCK = 2'd2,
    RES_SDA_STUCK = 2'd3
  } resultT;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic timerLoad;
    logic pulseClr;
    logic pulseInc;
    logic busyClr;
    logic sclDrive;
    logic sdaDrive;
  } ctrlStrobesT;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic timerZero;
    logic pulseAtMax;
    logic sclHigh;
    logic sdaHigh;
    logic busBusy;
    logic busIdle;
  } dpStatusT;

endpackage

// File: rtl/unstickDatapath.sv
module unstickDatapath
  import unstickPkg::*;
#(
  parameter int TW          = 16,
  parameter int IW          = 16,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobesT   ctrl,
  input  logic [TW-1:0] halfPeriod,
  input  logic [IW-1:0] idleThresh,
  input  logic          busyClearReq,
  input  logic          sclIn,
  input  logic          sdaIn,
  output dpStatusT      stat,
  output logic          sclDriveLow,
  output logic          sdaDriveLow
);

  localparam int LANES = 2;
  localparam int PW    = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PULSE_LIMIT = PW'(MAX_PULSES);
  localparam logic [IW-1:0] IDLE_SAT    = '1;

  // Line synchronisers, lane 0 = SCL, lane 1 = SDA
  logic [LANES-1:0] rawLines;
  logic [LANES-1:0] syncLines;
  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < LANES; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawLines[g]};
    end
    assign syncLines[g] = chain[SYNC_STAGES-1];
  end

  logic sclS, sdaS, sclPrev, sdaPrev;
  assign sclS = syncLines[0];
  assign sdaS = syncLines[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic startDet, stopDet, lineEdge;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign lineEdge = (sclS ^ sclPrev) | (sdaS ^ sdaPrev);

  // Phase timer
  logic [TW-1:0] timer;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (ctrl.timerLoad)   timer <= halfPeriod;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  // Generated pulse counter
  logic [PW-1:0] pulseCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pulseCnt <= '0;
    else if (ctrl.pulseClr)  pulseCnt <= '0;
    else if (ctrl.pulseInc)  pulseCnt <= pulseCnt + 1'b1;
  end

  // Busy flag and idle monitor
  logic          busyQ;
  logic [IW-1:0] idleCnt;
  logic          idleNow;
  assign idleNow = busyQ && (idleCnt >= idleThresh);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (lineEdge || !busyQ) begin
      idleCnt <= '0;
    end else if (idleCnt != IDLE_SAT) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            busyQ <= 1'b0;
    else if (startDet)                                    busyQ <= 1'b1;
    else if (stopDet || ctrl.busyClr || (busyClearReq && idleNow)) busyQ <= 1'b0;
  end

  // Registered open-drain enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      sclDriveLow <= ctrl.sclDrive;
      sdaDriveLow <= ctrl.sdaDrive;
    end
  end

  assign stat.timerZero  = (timer == '0);
  assign stat.pulseAtMax = (pulseCnt == PULSE_LIMIT);
  assign stat.sclHigh    = sclS;
  assign stat.sdaHigh    = sdaS;
  assign stat.busBusy    = busyQ;
  assign stat.busIdle    = idleNow;

endmodule

// File: rtl/unstickControl.sv
module unstickControl
  import unstickPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        recoverReq,
  input  dpStatusT    stat,
  output ctrlStrobesT ctrl,
  output logic        slaveReinit,
  output logic        startArmed,
  output logic        masterSent,
  output logic        recoveryDone,
  output logic [1:0]  recoveryStatus
);

  typedef enum logic [3:0] {
    S_IDLE, S_REINIT, S_ARM, S_SETTLE, S_PULSE_LO, S_PULSE_HI,
    S_CLEAR, S_START, S_RELEASE, S_DONE
  } stateT;

  stateT  state, stateNext;
  logic   finish;
  resultT finishCode;
  resultT statusQ;

  always_comb begin
    stateNext  = state;
    ctrl       = '0;
    finish     = 1'b0;
    finishCode = RES_NONE;
    unique case (state)
      S_IDLE:   if (recoverReq) stateNext = S_REINIT;
      S_REINIT: begin
        ctrl.pulseClr = 1'b1;
        stateNext     = S_ARM;
      end
      S_ARM: begin
        ctrl.timerLoad = 1'b1;
        stateNext      = S_SETTLE;
      end
      S_SETTLE: if (stat.timerZero) begin
        if (!stat.sclHigh) begin
          finish     = 1'b1;
          finishCode = RES_SCL_STUCK;
        end else if (stat.sdaHigh) begin
          stateNext = S_CLEAR;
        end else if (stat.pulseAtMax) begin
          finish     = 1'b1;
          finishCode = RES_SDA_STUCK;
        end else begin
          ctrl.pulseInc  = 1'b1;
          ctrl.timerLoad = 1'b1;
          stateNext      = S_PULSE_LO;
        end
      end
      S_PULSE_LO: begin
        ctrl.sclDrive = 1'b1;
        if (stat.timerZero) begin
          ctrl.timerLoad = 1'b1;
          stateNext      = S_PULSE_HI;
        end
      end
      S_PULSE_HI: if (stat.timerZero) begin
        ctrl.timerLoad = 1'b1;
        stateNext      = S_SETTLE;
      end
      S_CLEAR: if (!stat.busBusy || stat.busIdle) begin
        ctrl.busyClr   = 1'b1;
        ctrl.timerLoad = 1'b1;
        stateNext      = S_START;
      end
      S_START: begin
        ctrl.sdaDrive = 1'b1;
        if (stat.timerZero) begin
          ctrl.timerLoad = 1'b1;
          stateNext      = S_RELEASE;
        end
      end
      S_RELEASE: if (stat.timerZero) begin
        finish     = 1'b1;
        finishCode = RES_OK;
      end
      S_DONE:   stateNext = S_IDLE;
      default:  stateNext = S_IDLE;
    endcase
    if (finish) stateNext = S_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      statusQ    <= RES_NONE;
      masterSent <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == S_REINIT) begin
        statusQ    <= RES_NONE;
        masterSent <= 1'b0;
      end else begin
        if (finish)            statusQ    <= finishCode;
        if (state == S_START)  masterSent <= 1'b1;
      end
    end
  end

  assign slaveReinit    = (state == S_REINIT);
  assign startArmed     = (state != S_IDLE) && (state != S_REINIT) && (state != S_DONE);
  assign recoveryDone   = (state == S_DONE);
  assign recoveryStatus = statusQ;

endmodule

// File: rtl/twb_unstick.sv
module twb_unstick
  import unstickPkg::*;
#(
  parameter int TW          = 16,
  parameter int IW          = 16,
  parameter int MAX_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          recoverReq,
  input  logic          busyClearReq,
  input  logic [TW-1:0] halfPeriod,
  input  logic [IW-1:0] idleThresh,
  input  logic          sclIn,
  input  logic          sdaIn,
  output logic          sclDriveLow,
  output logic          sdaDriveLow,
  output logic          slaveReinit,
  output logic          startArmed,
  output logic          masterSent,
  output logic          busBusy,
  output logic          busIdle,
  output logic          recoveryDone,
  output logic [1:0]    recoveryStatus
);

  ctrlStrobesT ctrl;
  dpStatusT    stat;

  unstickControl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .recoverReq     (recoverReq),
    .stat           (stat),
    .ctrl           (ctrl),
    .slaveReinit    (slaveReinit),
    .startArmed     (startArmed),
    .masterSent     (masterSent),
    .recoveryDone   (recoveryDone),
    .recoveryStatus (recoveryStatus)
  );

  unstickDatapath #(
    .TW          (TW),
    .IW          (IW),
    .MAX_PULSES  (MAX_PULSES),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .halfPeriod   (halfPeriod),
    .idleThresh   (idleThresh),
    .busyClearReq (busyClearReq),
    .sclIn        (sclIn),
    .sdaIn        (sdaIn),
    .stat         (stat),
    .sclDriveLow  (sclDriveLow),
    .sdaDriveLow  (sdaDriveLow)
  );

  assign busBusy = stat.busBusy;
  assign busIdle = stat.busIdle;

endmodule

// File: rtl/twb_unstick_checker.sv
module twb_unstick_checker #(
  parameter int MAX_PULSES = 9
) (
  input logic       clk,
  input logic       rstN,
  input logic       slaveReinit,
  input logic       startArmed,
  input logic       masterSent,
  input logic       sclDriveLow,
  input logic       sdaDriveLow,
  input logic       busBusy,
  input logic       busIdle,
  input logic       recoveryDone,
  input logic [1:0] recoveryStatus
);

  localparam int CW = $clog2(MAX_PULSES + 2);

  // Generated pulses since the last re-initialisation
  logic          sclDrivePrev;
  logic [CW-1:0] drivenPulses;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclDrivePrev <= 1'b0;
      drivenPulses <= '0;
    end else begin
      sclDrivePrev <= sclDriveLow;
      if (slaveReinit)
        drivenPulses <= '0;
      else if (sclDriveLow && !sclDrivePrev && drivenPulses != '1)
        drivenPulses <= drivenPulses + 1'b1;
    end
  end

  assert_reinit_pulse_R1: assert property (@(posedge clk) disable iff (!rstN)
    slaveReinit |=> (!slaveReinit && startArmed));

  assert_scl_stuck_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (recoveryDone && recoveryStatus == 2'd2) |-> (!sdaDriveLow && !masterSent && drivenPulses == '0));

  assert_single_line_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(sclDriveLow && sdaDriveLow));

  assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    drivenPulses <= CW'(MAX_PULSES));

  assert_start_on_free_bus_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(masterSent) |-> !busBusy);

  assert_idle_needs_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busIdle |-> busBusy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    recoveryDone |=> !recoveryDone);

  assert_done_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    recoveryDone |-> (recoveryStatus != 2'd0));

endmodule

bind twb_unstick twb_unstick_checker #(.MAX_PULSES(MAX_PULSES)) uChecker (
  .clk            (clk),
  .rstN           (rstN),
  .slaveReinit    (slaveReinit),
  .startArmed     (startArmed),
  .masterSent     (masterSent),
  .sclDriveLow    (sclDriveLow),
  .sdaDriveLow    (sdaDriveLow),
  .busBusy        (busBusy),
  .busIdle        (busIdle),
  .recoveryDone   (recoveryDone),
  .recoveryStatus (recoveryStatus)
);

// File: tb/tb_twb_unstick.sv
`timescale 1ns/1ps
module tb_twb_unstick;

  localparam int HALF = 4;
  localparam int IDLE = 20;
  localparam int MAXP = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        recoverReq = 1'b0;
  logic        busyClearReq = 1'b0;
  logic        tbSclLow = 1'b0;
  logic        tbSdaLow = 1'b0;
  logic        sclDriveLow, sdaDriveLow, slaveReinit, startArmed, masterSent;
  logic        busBusy, busIdle, recoveryDone;
  logic [1:0]  recoveryStatus;
  logic        scl, sda;

  always #4 clk = ~clk;  // 125 MHz

  assign scl = !(sclDriveLow || tbSclLow);
  assign sda = !(sdaDriveLow || tbSdaLow);

  twb_unstick dut (
    .clk(clk), .rstN(rstN), .recoverReq(recoverReq), .busyClearReq(busyClearReq),
    .halfPeriod(16'(HALF)), .idleThresh(16'(IDLE)), .sclIn(scl), .sdaIn(sda),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .slaveReinit(slaveReinit),
    .startArmed(startArmed), .masterSent(masterSent), .busBusy(busBusy), .busIdle(busIdle),
    .recoveryDone(recoveryDone), .recoveryStatus(recoveryStatus)
  );

  int  testsRun = 0;
  int  testsFailed = 0;
  bit  finished = 0;

  // Bus line monitor
  logic prevScl = 1'b1, prevSda = 1'b1;
  int   fallCnt, lowRun, highRun, minLow, minHigh, releaseAfter;
  bit   seenRise, sawStart, sawStop, sawSdaDrive;

  task automatic clearStats();
    fallCnt = 0; lowRun = 0; highRun = 0; minLow = 1000; minHigh = 1000;
    seenRise = 0; sawStart = 0; sawStop = 0; sawSdaDrive = 0; releaseAfter = -1;
  endtask

  always @(negedge clk) begin
    if (scl && !prevScl) begin
      if (lowRun < minLow) minLow = lowRun;
      lowRun = 0; highRun = 0; seenRise = 1;
    end else if (!scl && prevScl) begin
      fallCnt++;
      if (seenRise && highRun < minHigh) minHigh = highRun;
      highRun = 0; lowRun = 0;
    end
    if (scl) highRun++; else lowRun++;
    if (scl && prevScl && prevSda && !sda) sawStart = 1;
    if (scl && prevScl && !prevSda && sda) sawStop = 1;
    if (sdaDriveLow) sawSdaDrive = 1;
    if (releaseAfter >= 0 && fallCnt >= releaseAfter && !scl) begin
      tbSdaLow = 1'b0;
      releaseAfter = -1;
    end
    prevScl = scl;
    prevSda = sda;
  end

  task automatic check(input bit ok, input string tag, input int actual, input int expected);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Issue a recovery request and wait for its end; checks R1 and R11 on the way
  task automatic runRecovery(output int status);
    bit seen = 0;
    @(negedge clk) recoverReq = 1'b1;
    @(negedge clk) recoverReq = 1'b0;
    check(slaveReinit == 1'b1, "R1 reinit pulse", int'(slaveReinit), 1);
    @(negedge clk);
    check(slaveReinit == 1'b0 && startArmed == 1'b1, "R1 armed after reinit",
          int'({slaveReinit, startArmed}), 1);
    check(recoveryStatus == 2'd0, "R11 status cleared while running", int'(recoveryStatus), 0);
    status = -1;
    for (int i = 0; i < 4000 && !seen; i++) begin
      @(negedge clk);
      if (recoveryDone) begin
        seen = 1;
        status = int'(recoveryStatus);
      end
    end
    check(seen, "R11 done pulse seen", int'(seen), 1);
    @(negedge clk);
    check(recoveryDone == 1'b0 && int'(recoveryStatus) == status, "R11 single-cycle done, held code",
          int'(recoveryDone), 0);
  endtask

  task automatic testReset();
    check(!sclDriveLow && !sdaDriveLow && !slaveReinit && !startArmed && !masterSent &&
          !busBusy && !busIdle && !recoveryDone && recoveryStatus == 2'd0,
          "R11 reset state", int'({sclDriveLow, sdaDriveLow, busBusy, recoveryStatus}), 0);
  endtask

  task automatic testFreeBus();
    int st;
    clearStats();
    runRecovery(st);
    check(fallCnt == 0, "R4 no pulses when SDA high", fallCnt, 0);
    check(st == 1, "R7 success code", st, 1);
    check(sawStart && sawStop, "R7 start then stop seen", int'({sawStart, sawStop}), 3);
    check(masterSent == 1'b1, "R7 masterSent", int'(masterSent), 1);
    check(busBusy == 1'b0, "R8 busy cleared by stop", int'(busBusy), 0);
  endtask

  task automatic testReleaseAfter(input int n);
    int st;
    tbSdaLow = 1'b1;               // slave holds SDA low: looks like a Start
    waitCycles(6);
    check(busBusy == 1'b1, "R8 busy set on start condition", int'(busBusy), 1);
    clearStats();
    releaseAfter = n;
    runRecovery(st);
    check(fallCnt == n, "R3 one pulse per low sample", fallCnt, n);
    check(minLow >= HALF, "R5 low phase width", minLow, HALF);
    check(minHigh >= HALF, "R5 high phase width", minHigh, HALF);
    check(st == 1, "R7 success after release", st, 1);
    check(sawStart && sawStop && masterSent, "R7 start sent", int'({sawStart, sawStop, masterSent}), 7);
    check(busBusy == 1'b0, "R8 busy clear at end", int'(busBusy), 0);
  endtask

  task automatic testSdaStuck();
    int st;
    tbSdaLow = 1'b1;
    waitCycles(6);
    clearStats();
    runRecovery(st);
    check(fallCnt == MAXP, "R6 pulse limit", fallCnt, MAXP);
    check(st == 3, "R6 SDA stuck code", st, 3);
    check(masterSent == 1'b0 && !sawSdaDrive, "R6 no start", int'(masterSent), 0);
    tbSdaLow = 1'b0;
    waitCycles(6);
  endtask

  task automatic testSclStuck();
    int st;
    tbSclLow = 1'b1;
    waitCycles(6);
    clearStats();
    runRecovery(st);
    check(st == 2, "R2 SCL stuck code", st, 2);
    check(fallCnt == 0 && !sclDriveLow, "R2 no pulses", fallCnt, 0);
    check(!sawSdaDrive && !masterSent, "R2 no SDA drive", int'(sawSdaDrive), 0);
    tbSclLow = 1'b0;
    waitCycles(6);
  endtask

  task automatic testBusyClear();
    tbSdaLow = 1'b1;
    waitCycles(6);
    check(busBusy == 1'b1, "R8 busy set", int'(busBusy), 1);
    @(negedge clk) busyClearReq = 1'b1;
    @(negedge clk) busyClearReq = 1'b0;
    waitCycles(2);
    check(busBusy == 1'b1, "R10 clear ignored when not idle", int'(busBusy), 1);
    waitCycles(IDLE + 5);
    check(busIdle == 1'b1, "R9 idle after threshold", int'(busIdle), 1);
    tbSclLow = 1'b1;
    waitCycles(3);
    tbSclLow = 1'b0;
    waitCycles(4);
    check(busIdle == 1'b0 && busBusy == 1'b1, "R9 edge restarts idle count",
          int'({busIdle, busBusy}), 1);
    waitCycles(IDLE + 5);
    check(busIdle == 1'b1, "R9 idle again", int'(busIdle), 1);
    @(negedge clk) busyClearReq = 1'b1;
    @(negedge clk) busyClearReq = 1'b0;
    waitCycles(1);
    check(busBusy == 1'b0 && busIdle == 1'b0, "R10 clear taken when idle", int'(busBusy), 0);
    tbSdaLow = 1'b0;
    waitCycles(6);
  endtask

  initial begin
    clearStats();
    waitCycles(10);
    rstN = 1'b1;
    waitCycles(3);
    testReset();
    testFreeBus();
    testReleaseAfter(3);
    testReleaseAfter(1);
    testSdaStuck();
    testSclStuck();
    testBusyClear();
    testFreeBus();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule